// File: doc/BRIEF.md
# Software-Timed SPI Pin Register Unit

This peripheral gives software direct control of a set of SPI pins through a 32-bit register bus. No hardware generates the serial clock. Each bus write to the pin-control word sets the levels of the clock, data-out and three chip-select lines. Software makes one bit period from two writes: the first places the data with the clock low, and the second raises the clock. Bytes go out most significant bit first.

Data coming back from the device is recorded as the pins move. Every rising edge of the clock pin shifts a capture register one place left and loads the serial input into its lowest bit. After eight clock pulses, software reads the received byte from the low eight bits of that register.

The pins follow the pin-control word only while a mode-enable bit is set. While that bit is clear they stay idle: all chip selects deasserted, clock low and data low. A further control word is plain read/write storage and has no effect on the pins.

Top module: `spi_pin_bitbang`

## Requirements
- R1: Registers are decoded at word offsets 0x00 (mode enable, bit 0), 0x04 (scratch control word), 0x08 (pin-control word) and 0x0C (capture register, read-only). The pin-control word reads back only its implemented bits, so a read returns the last written value ANDed with 0x0007_0101.
- R2: Reset clears the mode bit, the scratch word and the capture register. It sets the pin-control word to 0x0007_0000 and leaves cs_n = 3'b111, sclk = 0 and mosi = 0.
- R3: While mode enable is 1, mosi follows pin-control bit 0, sclk follows bit 8 and cs_n[n] follows bit 16+n for n = 0..2. Every other bit has no effect, and the pins change in the cycle after the write.
- R4: While mode enable is 0, cs_n = 3'b111, sclk = 0 and mosi = 0, whatever the pin-control word holds.
- R5: On each rising edge of the sclk pin, the capture register shifts left by one and takes miso (sampled at the next clock edge) into bit 0.
- R6: Without a rising sclk edge the capture register holds its value. This includes writes that keep the clock high, falling edges, and clock toggles in the pin-control word while mode enable is 0.
- R7: A byte sent with eight two-write bit periods appears on mosi MSB first. The byte returned on miso is then in capture bits [7:0], with the first bit received in bit 7.
- R8: Writes to the scratch word at 0x04 are read back in full and leave every pin unchanged.
- R9: Reads of any unmapped offset return zero. Writes to unmapped offsets change no register and no pin.
- R10: Writes to offset 0x0C leave the capture register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| miso | input | 1 | Serial data from the device |
| sclk | output | 1 | Serial clock pin |
| mosi | output | 1 | Serial data to the device |
| cs_n | output | 3 | Active-low chip selects |

## Verification
The bench sends a byte while returning a different byte. It checks mosi at every bit and then the captured value. A design that shifted on falling edges, or on every write, would return a byte rotated by one or stretched across bits. It repeats writes that keep the clock high and toggles the clock while the mode bit is off. A capture register that counts writes, or that watches the stored word instead of the pin, would gain extra bits there. It also writes unrelated bit patterns and writes to the read-only and unmapped offsets. A loose decode would then move chip selects, corrupt the capture register, or return stale data in place of zero.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;

    parameter int unsigned CS_COUNT = 3;
    localparam int unsigned BUS_W   = 32;

    localparam logic [31:0] OFS_MODE  = 32'h0000_0000;
    localparam logic [31:0] OFS_CTRL  = 32'h0000_0004;
    localparam logic [31:0] OFS_PINS  = 32'h0000_0008;
    localparam logic [31:0] OFS_SHIFT = 32'h0000_000C;

    localparam int unsigned BIT_MODE = 0;
    localparam int unsigned BIT_DOUT = 0;
    localparam int unsigned BIT_SCLK = 8;
    localparam int unsigned BIT_CS0  = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_CTRL,
        SEL_PINS,
        SEL_SHIFT
    } reg_sel_e;

    typedef struct packed {
        logic [CS_COUNT-1:0] cs_n;
        logic                clk;
        logic                dout;
    } pin_word_t;

    localparam pin_word_t PINS_IDLE = '{cs_n: '1, clk: 1'b0, dout: 1'b0};

    function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
        case (ofs)
            OFS_MODE:  return SEL_MODE;
            OFS_CTRL:  return SEL_CTRL;
            OFS_PINS:  return SEL_PINS;
            OFS_SHIFT: return SEL_SHIFT;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic pin_word_t unpack_pins(input logic [BUS_W-1:0] w);
        pin_word_t p;
        p.dout = w[BIT_DOUT];
        p.clk  = w[BIT_SCLK];
        p.cs_n = w[BIT_CS0 +: CS_COUNT];
        return p;
    endfunction

    function automatic logic [BUS_W-1:0] pack_pins(input pin_word_t p);
        logic [BUS_W-1:0] w;
        w = '0;
        w[BIT_DOUT]             = p.dout;
        w[BIT_SCLK]             = p.clk;
        w[BIT_CS0 +: CS_COUNT]  = p.cs_n;
        return w;
    endfunction

endpackage

// File: rtl/spi_pin_regfile.sv
module spi_pin_regfile
    import spi_pin_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned SHIFT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [SHIFT_W-1:0] shift_q,
    output logic [BUS_W-1:0]  rdata,
    output logic              mode_en,
    output pin_word_t         pins_q
);

    reg_sel_e         sel;
    logic [BUS_W-1:0] ctrl_q;

    always_comb sel = decode_offset(32'(addr));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_en <= 1'b0;
            ctrl_q  <= '0;
            pins_q  <= PINS_IDLE;
        end else if (we) begin
            case (sel)
                SEL_MODE: mode_en <= wdata[BIT_MODE];
                SEL_CTRL: ctrl_q  <= wdata;
                SEL_PINS: pins_q  <= unpack_pins(wdata);
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_MODE:  rdata = BUS_W'(mode_en);
            SEL_CTRL:  rdata = ctrl_q;
            SEL_PINS:  rdata = pack_pins(pins_q);
            SEL_SHIFT: rdata = BUS_W'(shift_q);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_pin_drive.sv
module spi_pin_drive
    import spi_pin_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_en,
    input  pin_word_t           pins_q,
    output logic                sclk,
    output logic                mosi,
    output logic [CS_COUNT-1:0] cs_n,
    output logic                sclk_rise
);

    pin_word_t live;
    logic      sclk_prev;

    always_comb live = mode_en ? pins_q : PINS_IDLE;

    for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
        assign cs_n[i] = live.cs_n[i];
    end

    assign sclk = live.clk;
    assign mosi = live.dout;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= live.clk;
    end

    assign sclk_rise = live.clk & ~sclk_prev;

endmodule

// File: rtl/spi_pin_capture.sv
module spi_pin_capture #(
    parameter int unsigned SHIFT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_rise,
    input  logic               miso,
    output logic [SHIFT_W-1:0] shift_q
);

    always_ff @(posedge clk) begin
        if (rst)            shift_q <= '0;
        else if (sclk_rise) shift_q <= {shift_q[SHIFT_W-2:0], miso};
    end

endmodule

// File: rtl/spi_pin_bitbang.sv
module spi_pin_bitbang
    import spi_pin_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned SHIFT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic [CS_COUNT-1:0] cs_n
);

    logic               mode_en;
    pin_word_t          pins_q;
    logic               sclk_rise;
    logic [SHIFT_W-1:0] shift_q;

    spi_pin_regfile #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .shift_q (shift_q),
        .rdata   (bus_rdata),
        .mode_en (mode_en),
        .pins_q  (pins_q)
    );

    spi_pin_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .mode_en   (mode_en),
        .pins_q    (pins_q),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n),
        .sclk_rise (sclk_rise)
    );

    spi_pin_capture #(.SHIFT_W(SHIFT_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (sclk_rise),
        .miso      (miso),
        .shift_q   (shift_q)
    );

endmodule

// File: rtl/spi_pin_chk.sv
module spi_pin_chk
    import spi_pin_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned SHIFT_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic [BUS_W-1:0]    bus_rdata,
    input logic                miso,
    input logic                sclk,
    input logic                mosi,
    input logic [CS_COUNT-1:0] cs_n,
    input logic                mode_en,
    input logic [SHIFT_W-1:0]  shift_q
);

    reg_sel_e sel;
    always_comb sel = decode_offset(32'(bus_addr));

    AST_PIN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_PINS && mode_en) |=>
        (sclk == $past(bus_wdata[BIT_SCLK]) && mosi == $past(bus_wdata[BIT_DOUT])
         && cs_n == $past(bus_wdata[BIT_CS0 +: CS_COUNT]))); // R3

    AST_IDLE_AFTER_OFF: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_MODE && !bus_wdata[BIT_MODE]) |=>
        (cs_n == '1 && !sclk && !mosi)); // R4

    AST_SHIFT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |=> shift_q == {$past(shift_q[SHIFT_W-2:0]), $past(miso)}); // R5

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$rose(sclk) |=> $stable(shift_q)); // R6

    AST_CTRL_NO_PIN: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_CTRL) |=> ($stable(sclk) && $stable(mosi) && $stable(cs_n))); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> bus_rdata == '0); // R9

endmodule

bind spi_pin_bitbang spi_pin_chk #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .mode_en   (mode_en),
    .shift_q   (shift_q)
);

// File: tb/sim_spi_pin_bitbang.sv
module sim_spi_pin_bitbang;
    import spi_pin_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        miso = 1'b0;
    logic [31:0] rdata;
    logic        sclk, mosi;
    logic [2:0]  cs_n;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_shift = '0;
    logic        done = 1'b0;

    spi_pin_bitbang u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [31:0] w;
        logic [4:0]  pins;
    } vec_t;

    // pins = {cs_n[2:0], sclk, mosi}, mode enabled, miso held low
    localparam vec_t VECS [6] = '{
        '{w: 32'h0007_0000, pins: 5'b111_0_0},
        '{w: 32'h0006_0001, pins: 5'b110_0_1},
        '{w: 32'h0005_0100, pins: 5'b101_1_0},
        '{w: 32'h0003_0101, pins: 5'b011_1_1},
        '{w: 32'h0000_0000, pins: 5'b000_0_0},
        '{w: 32'hFFF8_FEFE, pins: 5'b000_0_0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 v = rdata;
    endtask

    function automatic logic [31:0] pins_now();
        return {27'b0, cs_n, sclk, mosi};
    endfunction

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, held;
        logic [7:0]  tx, rx;
        tx = 8'hB4;
        rx = 8'h6D;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        check("R2 pins", pins_now(), 32'b111_0_0);
        rd(8'h00, v); check("R2 mode", v, 32'h0);
        rd(8'h08, v); check("R2 pin word", v, 32'h0007_0000);
        rd(8'h0C, v); check("R2 capture", v, 32'h0);

        // R4 disabled: pins stay idle
        wr(8'h08, 32'h0000_0101);
        check("R4 idle", pins_now(), 32'b111_0_0);
        rd(8'h08, v); check("R1 pin readback", v, 32'h0000_0101);

        // enable: pins take the word, clock rises with miso low
        wr(8'h00, 32'h1);
        check("R3 enable", pins_now(), 32'b000_1_1);
        rd(8'h00, v); check("R1 mode readback", v, 32'h1);
        exp_shift = {exp_shift[30:0], 1'b0};

        // table walk: R3 pin mapping, R1 readback masking
        for (int i = 0; i < 6; i++) begin
            wr(8'h08, VECS[i].w);
            check("R3 table pins", pins_now(), {27'b0, VECS[i].pins});
            rd(8'h08, v); check("R1 table readback", v, VECS[i].w & 32'h0007_0101);
            if (VECS[i].w[8] && (i == 0 || !VECS[i-1].w[8]))
                exp_shift = {exp_shift[30:0], 1'b0};
        end
        rd(8'h0C, v); check("R5 capture after table", v, exp_shift);

        // R7 byte exchange
        for (int i = 7; i >= 0; i--) begin
            miso = rx[i];
            wr(8'h08, 32'h0006_0000 | 32'(tx[i]));
            wr(8'h08, 32'h0006_0100 | 32'(tx[i]));
            check("R7 mosi bit", {31'b0, mosi}, {31'b0, tx[i]});
            @(negedge clk);
            exp_shift = {exp_shift[30:0], rx[i]};
        end
        rd(8'h0C, v);
        check("R7 received byte", {24'b0, v[7:0]}, {24'b0, rx});
        check("R5 capture full", v, exp_shift);

        // R5 one more pulse
        miso = 1'b1;
        wr(8'h08, 32'h0006_0000);
        wr(8'h08, 32'h0006_0100);
        @(negedge clk);
        exp_shift = {exp_shift[30:0], 1'b1};
        rd(8'h0C, v); check("R5 extra pulse", v, exp_shift);

        // R6 no rising edge -> hold
        wr(8'h08, 32'h0006_0101);
        @(negedge clk);
        rd(8'h0C, v); check("R6 clock held high", v, exp_shift);
        wr(8'h08, 32'h0006_0000);
        @(negedge clk);
        rd(8'h0C, v); check("R6 falling edge", v, exp_shift);
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h0006_0100);
        check("R4 idle with clock bit", pins_now(), 32'b111_0_0);
        @(negedge clk);
        rd(8'h0C, v); check("R6 toggle while off", v, exp_shift);
        wr(8'h08, 32'h0006_0000);
        wr(8'h00, 32'h1);
        @(negedge clk);
        rd(8'h0C, v); check("R6 enable clock low", v, exp_shift);

        // R10 capture not writable
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, v); check("R10 capture write", v, exp_shift);

        // R8 scratch word
        held = pins_now();
        wr(8'h04, 32'hA5A5_1234);
        check("R8 pins unchanged", pins_now(), held);
        rd(8'h04, v); check("R8 readback", v, 32'hA5A5_1234);

        // R9 unmapped
        rd(8'h10, v); check("R9 read 0x10", v, 32'h0);
        rd(8'hFC, v); check("R9 read 0xFC", v, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        check("R9 pins unchanged", pins_now(), held);
        rd(8'h08, v); check("R9 pin word unchanged", v, 32'h0006_0000);
        rd(8'h00, v); check("R9 mode unchanged", v, 32'h1);

        // R2 reset in the middle of activity
        wr(8'h08, 32'h0000_0101);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check("R2 pins after reset", pins_now(), 32'b111_0_0);
        rd(8'h0C, v); check("R2 capture after reset", v, 32'h0);
        rd(8'h04, v); check("R2 scratch after reset", v, 32'h0);
        rd(8'h08, v); check("R2 pin word after reset", v, 32'h0007_0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule